// File: doc/BRIEF.md
# Head Stepper Sequencer

This block positions a read/write head over one of forty tracks by driving the four phase windings of a stepper motor directly. Each motor step moves the head by exactly one track. The block keeps the head position in a register, and it derives the phase pattern from the steps it has taken.

A controller asks for a seek by pulsing a request together with a target track and a step spacing. The block then walks the head toward the target one track at a time. It holds `busy` high until the last step lands. A target beyond the last track is clamped to the last track. A target equal to the current track causes no motion. The spacing value sets the minimum number of clocks between steps, so that slow mechanics can settle.

Top module: `head_step_seq`

## Requirements
- R1: After reset, `cur_track` is 0, `phase` is 4'b0001 (winding A, bit 0) and `busy` is low.
- R2: Exactly one bit of `phase` is high in every cycle after reset.
- R3: An inward step raises `cur_track` by one and rotates `phase` upward (bit 0 to bit 1, bit 1 to bit 2, bit 2 to bit 3, bit 3 to bit 0).
- R4: An outward step lowers `cur_track` by one and rotates `phase` downward, which is the reverse of R3.
- R5: Between two consecutive cycles, `cur_track` changes by at most one.
- R6: A requested target above 39 is treated as 39, and `cur_track` never exceeds 39.
- R7: A request whose clamped target equals `cur_track` causes no step, and `busy` stays low.
- R8: When a seek is accepted at a clock edge with spacing G, the first step happens G+1 edges later. Each later step follows the previous one by exactly G+1 edges. G is captured when the seek is accepted.
- R9: `busy` rises at the edge that accepts a seek. It falls at the edge of the final step, when `cur_track` reaches the target. While `busy` is low, `cur_track` does not change.
- R10: A request that arrives while `busy` is high is ignored. The ongoing seek still ends at its original target.
- R11: `phase` always equals 4'b0001 shifted left by (`cur_track` mod 4).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seek_req | input | 1 | One-cycle pulse that requests a seek |
| seek_target | input | 6 | Target track for the request |
| step_gap | input | 8 | Spacing G; steps are G+1 clocks apart |
| busy | output | 1 | High while a seek is in progress |
| cur_track | output | 6 | Current head track, 0..39 |
| phase | output | 4 | One-hot winding drive, bit 0 = A |

## Verification
The tests use several seeks. A long inward seek with a non-zero spacing shows whether the first-step delay and the repeat spacing are each G+1 clocks. An outward seek with zero spacing checks the reverse rotation and back-to-back stepping. An over-range target and a repeated request for the same track separate clamping from the case where no move is needed. A request injected in the middle of a seek shows whether the block latches a new target while busy. A reference model in the bench steps in parallel with the block, so each wrong cycle in busy timing, track or phase is reported at the cycle where it happens.

// File: rtl/hss_pkg.sv
package hss_pkg;

  localparam int PHASES = 4;

  typedef logic [PHASES-1:0] phase_t;

  // winding pattern after one step toward higher track numbers
  function automatic phase_t rot_inward(input phase_t p);
    return {p[PHASES-2:0], p[PHASES-1]};
  endfunction

  // winding pattern after one step toward track 0
  function automatic phase_t rot_outward(input phase_t p);
    return {p[0], p[PHASES-1:1]};
  endfunction

endpackage

// File: rtl/hss_pace.sv
module hss_pace #(
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [GAP_W-1:0] gap_in,
  input  logic             run,
  output logic             fire
);

  logic [GAP_W-1:0] gap_q;
  logic [GAP_W-1:0] cnt_q;

  assign fire = run && (cnt_q >= gap_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= '0;
      cnt_q <= '0;
    end else if (load) begin
      gap_q <= gap_in;
      cnt_q <= '0;
    end else if (run) begin
      if (fire) cnt_q <= '0;
      else      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/hss_pos.sv
module hss_pos #(
  parameter int TW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  input  logic            dir_in,
  output logic [TW-1:0]   track,
  output hss_pkg::phase_t phase
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      track <= '0;
      phase <= hss_pkg::phase_t'(1);
    end else if (step) begin
      if (dir_in) begin
        track <= track + 1'b1;
        phase <= hss_pkg::rot_inward(phase);
      end else begin
        track <= track - 1'b1;
        phase <= hss_pkg::rot_outward(phase);
      end
    end
  end

endmodule

// File: rtl/head_step_seq.sv
module head_step_seq #(
  parameter int TRACKS = 40,
  parameter int GAP_W  = 8,
  localparam int TW    = $clog2(TRACKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seek_req,
  input  logic [TW-1:0]    seek_target,
  input  logic [GAP_W-1:0] step_gap,
  output logic             busy,
  output logic [TW-1:0]    cur_track,
  output logic [3:0]       phase
);

  localparam logic [TW-1:0] LAST = TW'(TRACKS - 1);

  logic [TW-1:0] tgt_clamped;
  logic [TW-1:0] tgt_q;
  logic          busy_q;
  logic          accept;
  logic          step_fire;
  logic          dir_in;
  logic          last_step;

  assign tgt_clamped = (seek_target > LAST) ? LAST : seek_target;
  assign accept      = seek_req && !busy_q && (tgt_clamped != cur_track);
  assign dir_in      = tgt_q > cur_track;
  assign last_step   = step_fire &&
                       (dir_in ? (TW'(cur_track + 1'b1) == tgt_q)
                               : (TW'(cur_track - 1'b1) == tgt_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      tgt_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      tgt_q  <= tgt_clamped;
    end else if (last_step) begin
      busy_q <= 1'b0;
    end
  end

  hss_pace #(.GAP_W(GAP_W)) u_pace (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept),
    .gap_in (step_gap),
    .run    (busy_q),
    .fire   (step_fire)
  );

  hss_pos #(.TW(TW)) u_pos (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (step_fire),
    .dir_in (dir_in),
    .track  (cur_track),
    .phase  (phase)
  );

  assign busy = busy_q;

endmodule

// File: rtl/hss_chk.sv
module hss_chk #(
  parameter int TRACKS = 40,
  parameter int GAP_W  = 8,
  localparam int TW    = $clog2(TRACKS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             seek_req,
  input logic [TW-1:0]    seek_target,
  input logic [GAP_W-1:0] step_gap,
  input logic             busy,
  input logic [TW-1:0]    cur_track,
  input logic [3:0]       phase,
  input logic             step_fire
);

  localparam logic [TW-1:0] LAST = TW'(TRACKS - 1);

  logic [TW-1:0]    want;
  logic [GAP_W-1:0] gap_seen;
  logic [GAP_W:0]   wait_c;

  assign want = (seek_target > LAST) ? LAST : seek_target;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_seen <= '0;
      wait_c   <= '0;
    end else if (seek_req && !busy) begin
      gap_seen <= step_gap;
      wait_c   <= '0;
    end else if (busy) begin
      wait_c <= step_fire ? '0 : wait_c + 1'b1;
    end
  end

  AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(phase) == 1);  // R2
  AST_TRACK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cur_track <= LAST);  // R6
  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_track != $past(cur_track)) |->
      (cur_track == TW'($past(cur_track) + 1'b1) || TW'(cur_track + 1'b1) == $past(cur_track)));  // R5
  AST_PHASE_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    phase == (4'b0001 << cur_track[1:0]));  // R11
  AST_STEP_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire |-> busy);  // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(cur_track));  // R9
  AST_SAME_TRACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (seek_req && !busy && want == cur_track) |=> !busy);  // R7
  AST_STEP_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (step_fire == (wait_c == {1'b0, gap_seen})));  // R8

endmodule

bind head_step_seq hss_chk #(.TRACKS(TRACKS), .GAP_W(GAP_W)) u_hss_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .seek_req    (seek_req),
  .seek_target (seek_target),
  .step_gap    (step_gap),
  .busy        (busy),
  .cur_track   (cur_track),
  .phase       (phase),
  .step_fire   (step_fire)
);

// File: tb/head_step_seq_tb.sv
`timescale 1ns/1ps
module head_step_seq_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       seek_req = 1'b0;
  logic [5:0] seek_target = '0;
  logic [7:0] step_gap = '0;
  logic       busy;
  logic [5:0] cur_track;
  logic [3:0] phase;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  // reference model state
  int m_track = 0;
  int m_busy = 0;
  int m_tgt = 0;
  int m_gap = 0;
  int m_wait = 0;
  int prev_track = 0;

  always #4 clk = ~clk;

  head_step_seq dut_i (
    .clk(clk), .rst_n(rst_n), .seek_req(seek_req), .seek_target(seek_target),
    .step_gap(step_gap), .busy(busy), .cur_track(cur_track), .phase(phase)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_track = 0; m_busy = 0; m_wait = 0;
    end else if (m_busy == 0) begin
      if (seek_req) begin
        int t;
        t = (seek_target > 39) ? 39 : int'(seek_target);
        if (t != m_track) begin
          m_busy = 1; m_tgt = t; m_gap = int'(step_gap); m_wait = 0;
        end
      end
    end else begin
      if (m_wait >= m_gap) begin
        m_track += (m_tgt > m_track) ? 1 : -1;
        m_wait = 0;
        if (m_track == m_tgt) m_busy = 0;
      end else m_wait++;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R9 busy vs model", int'(busy), m_busy);
      chk("R3/R4 track vs model", int'(cur_track), m_track);
      chk("R11 phase vs track", int'(phase), 1 << (m_track % 4));
      chk("R2 phase one-hot", $countones(phase), 1);
      chk("R5 step size", (int'(cur_track) - prev_track) inside {-1, 0, 1}, 1);
      prev_track = int'(cur_track);
    end
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<=100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // returns number of cycles busy was high; optional mid-seek request
  task automatic do_seek(input int tgt, input int gap, input bit inject, output int n);
    seek_req = 1'b1; seek_target = 6'(tgt); step_gap = 8'(gap);
    @(negedge clk);
    seek_req = 1'b0;
    n = 0;
    while (busy) begin
      n++;
      if (inject && n == 3) begin
        seek_req = 1'b1; seek_target = 6'd0; step_gap = 8'd0;
      end else seek_req = 1'b0;
      @(negedge clk);
    end
    seek_req = 1'b0;
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset track", int'(cur_track), 0);
    chk("R1 reset phase", int'(phase), 1);
    chk("R1 reset busy", int'(busy), 0);

    do_seek(5, 2, 1'b1, n);
    chk("R8 busy cycles 5 steps gap 2", n, 15);
    chk("R10 mid-seek request ignored", int'(cur_track), 5);
    chk("R3 inward phase", int'(phase), 4'b0010);

    do_seek(2, 0, 1'b0, n);
    chk("R8 busy cycles 3 steps gap 0", n, 3);
    chk("R4 outward track", int'(cur_track), 2);
    chk("R4 outward phase", int'(phase), 4'b0100);

    do_seek(2, 0, 1'b0, n);
    chk("R7 same target no busy", n, 0);
    chk("R7 same target track", int'(cur_track), 2);

    do_seek(63, 0, 1'b0, n);
    chk("R6 clamp to 39", int'(cur_track), 39);
    chk("R6 busy cycles", n, 37);
    chk("R3 phase at 39", int'(phase), 4'b1000);

    do_seek(45, 3, 1'b0, n);
    chk("R6 R7 over-range at last track no move", n, 0);

    do_seek(0, 1, 1'b0, n);
    chk("R4 return to 0", int'(cur_track), 0);
    chk("R8 busy cycles 39 steps gap 1", n, 78);
    chk("R11 phase at 0", int'(phase), 1);

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule